// File: doc/BRIEF.md
# SMBus Host Controller Register Front End

This block is the byte-wide register file that sits between a processor bus and an SMBus bus-master engine. Software programs a slave address, a command byte and up to two data bytes, then writes the control register with its start bit set. The block checks the chosen protocol and launches one transaction by sending a single-cycle request to the engine. When the engine reports completion, the block updates its status bits and loads any returned data into the data registers.

Status bits are cleared by writing a 1 to them, except the busy bit. A kill request stops a running transaction. A level interrupt is raised whenever an event bit in the status register is set and interrupts are enabled. Bit-level bus signalling, packet error checking and alert handling are done elsewhere. They reach this block only as response flags from the engine.

Top module: `smbh_host`

## Requirements
- R1: Registers sit at byte offsets status 0x0, control 0x2, command 0x3, slave address 0x4, data-low 0x5, data-high 0x6, block 0x7 and auxiliary 0xD. Reads of any other offset return 0. The auxiliary register keeps only its bits 1:0, and a read returns them with bits 7:2 as 0.
- R2: After a synchronous reset, every register reads 0, `irq` is low and no request or abort is driven.
- R3: A status write clears each status bit written as 1, except bit 0 (busy), which a write never changes. If an event sets a bit in the same cycle as a write clears it, the set wins.
- R4: The control register stores all written bits except bit 6 (start). A control read returns only bits 4:0.
- R5: A control write with bit 6 set, bit 1 clear and a protocol code in bits 4:2 between 0 and 6 starts a transaction, provided the block is not busy and status bit 2 is clear. The next cycle sets busy and pulses `eng_req` high for exactly one cycle. During that cycle `eng_proto` carries the code, `eng_rnw` carries address bit 0, `eng_slave` carries address bits 7:1 and `eng_cmd` carries the command register.
- R6: A start is ignored, with no request, while status bit 2 (device error) is set. A start with protocol code 7 issues no request and sets status bit 2.
- R7: A control write with bit 1 (kill) set clears busy, sets status bit 4 (failed) and pulses `eng_abort` for one cycle. It launches nothing, even if bit 6 is also set. An `eng_done` that arrives while the block is not busy is ignored.
- R8: An `eng_done` while busy clears busy. With `eng_nak` high it sets status bit 2; otherwise it sets status bit 1. `eng_bus_err` high at completion also sets status bit 3.
- R9: `eng_wdata` carries data-high in bits 15:8 and data-low in bits 7:0. On a successful completion, data is captured according to the launched protocol:
  - Code 1 or 2, read: data-low takes `eng_rdata[7:0]`.
  - Code 3, read, or code 4 in either direction: data-low takes bits 7:0 and data-high takes bits 15:8.
  - Code 5, read, or code 6: data-low takes the count in bits 7:0 and the block register takes bits 15:8. Status bit 7 is also set.
  - Code 0, and any write not listed above, changes no data register.
- R10: `irq` is high exactly when control bit 0 is 1 and any of status bits 7:1 is 1.
- R11: While busy, writes to the command, address, data-low, data-high and block registers are ignored.
- R12: A one-cycle `eng_alert` pulse sets status bit 5, whether or not a transaction is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Level interrupt |
| eng_req | output | 1 | One-cycle transaction launch |
| eng_abort | output | 1 | One-cycle kill to the engine |
| eng_proto | output | 3 | Protocol code of the launched transaction |
| eng_rnw | output | 1 | Direction, 1 for read |
| eng_slave | output | 7 | Slave address |
| eng_cmd | output | 8 | Command byte |
| eng_wdata | output | 16 | Data-high and data-low packed |
| eng_done | input | 1 | Completion pulse from the engine |
| eng_nak | input | 1 | Completion failed or not acknowledged |
| eng_bus_err | input | 1 | Bus error flagged at completion |
| eng_rdata | input | 16 | Returned data |
| eng_alert | input | 1 | Alert event pulse |

## Verification
Transactions are run with each capture variety: a word read, a byte read, a block read, a quick command and a word write. Together they show which data registers each protocol is allowed to touch. A NAK followed by a second start separates the device-error lockout from an ordinary completion, and the reserved protocol code shows the same lockout being armed without any request. A kill issued mid-transaction, followed by a late completion, checks that the abort path drops the engine's answer. Writes made during the busy window to the status and command registers confirm that busy is protected and the transaction fields stay frozen.

// File: rtl/smbh_pkg.sv
package smbh_pkg;
    localparam int DW  = 8;
    localparam int AW  = 4;
    localparam int EW  = 2 * DW;
    localparam int PW  = 3;
    localparam int SW  = DW - 1;
    localparam int XW  = 2;

    localparam logic [AW-1:0] OFS_STS = 4'h0;
    localparam logic [AW-1:0] OFS_CTL = 4'h2;
    localparam logic [AW-1:0] OFS_CMD = 4'h3;
    localparam logic [AW-1:0] OFS_ADR = 4'h4;
    localparam logic [AW-1:0] OFS_DLO = 4'h5;
    localparam logic [AW-1:0] OFS_DHI = 4'h6;
    localparam logic [AW-1:0] OFS_BLK = 4'h7;
    localparam logic [AW-1:0] OFS_AUX = 4'hD;

    localparam int CTL_IE    = 0;
    localparam int CTL_KILL  = 1;
    localparam int CTL_PLO   = 2;
    localparam int CTL_START = 6;

    localparam logic [DW-1:0] CTL_KEEP_MASK = 8'hBF;
    localparam logic [DW-1:0] CTL_READ_MASK = 8'h1F;
    localparam logic [DW-1:0] STS_W1C_MASK  = 8'hFE;

    typedef enum logic [PW-1:0] {
        PR_QUICK  = 3'd0,
        PR_BYTE   = 3'd1,
        PR_BDATA  = 3'd2,
        PR_WORD   = 3'd3,
        PR_PCALL  = 3'd4,
        PR_BLOCK  = 3'd5,
        PR_I2CBLK = 3'd6,
        PR_RSVD   = 3'd7
    } proto_e;

    typedef enum logic [1:0] {
        CAP_NONE,
        CAP_LOW,
        CAP_WORD,
        CAP_BLOCK
    } cap_e;

    typedef struct packed {
        logic byte_done;
        logic in_use;
        logic alert;
        logic failed;
        logic bus_err;
        logic dev_err;
        logic intr;
        logic busy;
    } stat_t;

    function automatic logic proto_ok(proto_e p);
        return p != PR_RSVD;
    endfunction

    function automatic cap_e capture_kind(proto_e p, logic rnw);
        case (p)
            PR_BYTE, PR_BDATA: return rnw ? CAP_LOW   : CAP_NONE;
            PR_WORD:           return rnw ? CAP_WORD  : CAP_NONE;
            PR_PCALL:          return CAP_WORD;
            PR_BLOCK:          return rnw ? CAP_BLOCK : CAP_NONE;
            PR_I2CBLK:         return CAP_BLOCK;
            default:           return CAP_NONE;
        endcase
    endfunction
endpackage

// File: rtl/smbh_seq.sv
module smbh_seq
    import smbh_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ctl_wr,
    input  logic [DW-1:0] wdata,
    input  logic          busy,
    input  logic          dev_err,
    input  logic          eng_done,
    output logic          start_ok,
    output logic          bad_start,
    output logic          kill,
    output logic          done_ok,
    output proto_e        proto_q,
    output logic          req_q,
    output logic          abort_q
);
    proto_e wr_proto;
    logic   go;

    always_comb begin
        wr_proto  = proto_e'(wdata[CTL_PLO +: PW]);
        go        = ctl_wr && wdata[CTL_START] && !wdata[CTL_KILL] && !busy && !dev_err;
        start_ok  = go && proto_ok(wr_proto);
        bad_start = go && !proto_ok(wr_proto);
        kill      = ctl_wr && wdata[CTL_KILL];
        done_ok   = eng_done && busy;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q   <= 1'b0;
            abort_q <= 1'b0;
            proto_q <= PR_QUICK;
        end else begin
            req_q   <= start_ok;
            abort_q <= kill;
            if (start_ok) proto_q <= wr_proto;
        end
    end
endmodule

// File: rtl/smbh_status.sv
module smbh_status
    import smbh_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          sts_wr,
    input  logic [DW-1:0] wdata,
    input  logic          start_ok,
    input  logic          bad_start,
    input  logic          kill,
    input  logic          done_ok,
    input  logic          nak,
    input  logic          bus_err,
    input  logic          alert,
    input  logic          block_rd,
    output stat_t         stat_q
);
    stat_t nxt;

    always_comb begin
        nxt = stat_q;
        if (sts_wr) nxt = stat_t'(stat_q & ~(wdata & STS_W1C_MASK));
        if (start_ok) nxt.busy = 1'b1;
        if (kill) begin
            nxt.busy   = 1'b0;
            nxt.failed = 1'b1;
        end
        if (done_ok) begin
            nxt.busy = 1'b0;
            if (nak) begin
                nxt.dev_err = 1'b1;
            end else begin
                nxt.intr = 1'b1;
                if (block_rd) nxt.byte_done = 1'b1;
            end
            if (bus_err) nxt.bus_err = 1'b1;
        end
        if (bad_start) nxt.dev_err = 1'b1;
        if (alert)     nxt.alert   = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= nxt;
    end
endmodule

// File: rtl/smbh_rdmux.sv
module smbh_rdmux
    import smbh_pkg::*;
(
    input  logic [AW-1:0] addr,
    input  stat_t         stat,
    input  logic [DW-1:0] ctl,
    input  logic [DW-1:0] cmd,
    input  logic [DW-1:0] adr,
    input  logic [DW-1:0] dlo,
    input  logic [DW-1:0] dhi,
    input  logic [DW-1:0] blk,
    input  logic [XW-1:0] aux,
    output logic [DW-1:0] rdata
);
    always_comb begin
        case (addr)
            OFS_STS: rdata = stat;
            OFS_CTL: rdata = ctl & CTL_READ_MASK;
            OFS_CMD: rdata = cmd;
            OFS_ADR: rdata = adr;
            OFS_DLO: rdata = dlo;
            OFS_DHI: rdata = dhi;
            OFS_BLK: rdata = blk;
            OFS_AUX: rdata = {{(DW-XW){1'b0}}, aux};
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/smbh_host.sv
module smbh_host
    import smbh_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq,
    output logic          eng_req,
    output logic          eng_abort,
    output logic [PW-1:0] eng_proto,
    output logic          eng_rnw,
    output logic [SW-1:0] eng_slave,
    output logic [DW-1:0] eng_cmd,
    output logic [EW-1:0] eng_wdata,
    input  logic          eng_done,
    input  logic          eng_nak,
    input  logic          eng_bus_err,
    input  logic [EW-1:0] eng_rdata,
    input  logic          eng_alert
);
    stat_t         stat_q;
    proto_e        proto_q;
    logic [DW-1:0] ctl_q, cmd_q, adr_q, dlo_q, dhi_q, blk_q;
    logic [XW-1:0] aux_q;
    logic          start_ok, bad_start, kill, done_ok;
    logic          ok_done, lock;
    cap_e          cap;

    smbh_seq u_seq (
        .clk(clk), .rst(rst),
        .ctl_wr(reg_wr && reg_addr == OFS_CTL),
        .wdata(reg_wdata),
        .busy(stat_q.busy), .dev_err(stat_q.dev_err),
        .eng_done(eng_done),
        .start_ok(start_ok), .bad_start(bad_start), .kill(kill), .done_ok(done_ok),
        .proto_q(proto_q), .req_q(eng_req), .abort_q(eng_abort)
    );

    always_comb begin
        cap     = capture_kind(proto_q, adr_q[0]);
        ok_done = done_ok && !eng_nak;
        lock    = stat_q.busy;
    end

    smbh_status u_status (
        .clk(clk), .rst(rst),
        .sts_wr(reg_wr && reg_addr == OFS_STS),
        .wdata(reg_wdata),
        .start_ok(start_ok), .bad_start(bad_start), .kill(kill), .done_ok(done_ok),
        .nak(eng_nak), .bus_err(eng_bus_err), .alert(eng_alert),
        .block_rd(cap == CAP_BLOCK),
        .stat_q(stat_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0; cmd_q <= '0; adr_q <= '0;
            dlo_q <= '0; dhi_q <= '0; blk_q <= '0; aux_q <= '0;
        end else begin
            if (reg_wr) begin
                case (reg_addr)
                    OFS_CTL: ctl_q <= reg_wdata & CTL_KEEP_MASK;
                    OFS_AUX: aux_q <= reg_wdata[XW-1:0];
                    OFS_CMD: if (!lock) cmd_q <= reg_wdata;
                    OFS_ADR: if (!lock) adr_q <= reg_wdata;
                    OFS_DLO: if (!lock) dlo_q <= reg_wdata;
                    OFS_DHI: if (!lock) dhi_q <= reg_wdata;
                    OFS_BLK: if (!lock) blk_q <= reg_wdata;
                    default: ;
                endcase
            end
            if (ok_done) begin
                case (cap)
                    CAP_LOW:   dlo_q <= eng_rdata[DW-1:0];
                    CAP_WORD:  begin
                        dlo_q <= eng_rdata[DW-1:0];
                        dhi_q <= eng_rdata[EW-1:DW];
                    end
                    CAP_BLOCK: begin
                        dlo_q <= eng_rdata[DW-1:0];
                        blk_q <= eng_rdata[EW-1:DW];
                    end
                    default: ;
                endcase
            end
        end
    end

    smbh_rdmux u_rdmux (
        .addr(reg_addr), .stat(stat_q), .ctl(ctl_q), .cmd(cmd_q), .adr(adr_q),
        .dlo(dlo_q), .dhi(dhi_q), .blk(blk_q), .aux(aux_q), .rdata(reg_rdata)
    );

    always_comb begin
        irq       = ctl_q[CTL_IE] && (stat_q[DW-1:1] != '0);
        eng_proto = proto_q;
        eng_rnw   = adr_q[0];
        eng_slave = adr_q[DW-1:1];
        eng_cmd   = cmd_q;
        eng_wdata = {dhi_q, dlo_q};
    end
endmodule

// File: rtl/smbh_host_chk.sv
module smbh_host_chk
    import smbh_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          reg_wr,
    input logic [AW-1:0] reg_addr,
    input logic          eng_done,
    input logic          eng_req,
    input logic          eng_abort,
    input logic          irq,
    input logic [DW-1:0] stat_q,
    input logic [DW-1:0] cmd_q
);
    a_r5_req_single: assert property (@(posedge clk) disable iff (rst)
        eng_req |=> !eng_req);

    a_r5_req_busy: assert property (@(posedge clk) disable iff (rst)
        eng_req |-> stat_q[0]);

    a_r7_abort_idle: assert property (@(posedge clk) disable iff (rst)
        eng_abort |-> !stat_q[0]);

    a_r6_deverr_blocks: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == OFS_CTL && stat_q[2]) |=> !eng_req);

    a_r3_busy_kept: assert property (@(posedge clk) disable iff (rst)
        (stat_q[0] && reg_wr && reg_addr == OFS_STS && !eng_done) |=> stat_q[0]);

    a_r8_done_frees: assert property (@(posedge clk) disable iff (rst)
        (eng_done && stat_q[0]) |=> !stat_q[0]);

    a_r11_cmd_locked: assert property (@(posedge clk) disable iff (rst)
        (stat_q[0] && reg_wr && reg_addr == OFS_CMD) |=> $stable(cmd_q));

    a_r10_quiet_irq: assert property (@(posedge clk) disable iff (rst)
        (stat_q[DW-1:1] == '0) |-> !irq);
endmodule

bind smbh_host smbh_host_chk u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .eng_done(eng_done), .eng_req(eng_req), .eng_abort(eng_abort), .irq(irq),
    .stat_q(stat_q), .cmd_q(cmd_q)
);

// File: tb/smbh_host_bench.sv
module smbh_host_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [7:0]  reg_wdata = 8'h0;
    logic [7:0]  reg_rdata;
    logic        irq, eng_req, eng_abort, eng_rnw;
    logic [2:0]  eng_proto;
    logic [6:0]  eng_slave;
    logic [7:0]  eng_cmd;
    logic [15:0] eng_wdata;
    logic        eng_done = 1'b0, eng_nak = 1'b0, eng_bus_err = 1'b0, eng_alert = 1'b0;
    logic [15:0] eng_rdata = 16'h0;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    smbh_host u_smbh_host (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .eng_req(eng_req), .eng_abort(eng_abort), .eng_proto(eng_proto),
        .eng_rnw(eng_rnw), .eng_slave(eng_slave), .eng_cmd(eng_cmd),
        .eng_wdata(eng_wdata), .eng_done(eng_done), .eng_nak(eng_nak),
        .eng_bus_err(eng_bus_err), .eng_rdata(eng_rdata), .eng_alert(eng_alert)
    );

    // Behavioural reference state
    logic [7:0] m_st, m_ctl, m_cmd, m_adr, m_dlo, m_dhi, m_blk;
    logic [1:0] m_aux;
    logic [2:0] m_pr;
    logic       m_req, m_abt;

    function automatic logic [7:0] m_read(logic [3:0] a);
        case (a)
            4'h0: return m_st;
            4'h2: return m_ctl & 8'h1F;
            4'h3: return m_cmd;
            4'h4: return m_adr;
            4'h5: return m_dlo;
            4'h6: return m_dhi;
            4'h7: return m_blk;
            4'hD: return {6'b0, m_aux};
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin : model
        logic ob, od, rd;
        if (rst) begin
            m_st = 0; m_ctl = 0; m_cmd = 0; m_adr = 0; m_dlo = 0; m_dhi = 0;
            m_blk = 0; m_aux = 0; m_pr = 0; m_req = 0; m_abt = 0;
        end else begin
            ob = m_st[0]; od = m_st[2]; rd = m_adr[0];
            m_req = 0; m_abt = 0;
            if (reg_wr && reg_addr == 4'h0) m_st = m_st & ~(reg_wdata & 8'hFE);
            if (eng_done && ob) begin
                m_st[0] = 0;
                if (eng_nak) m_st[2] = 1;
                else begin
                    m_st[1] = 1;
                    if ((m_pr == 1 || m_pr == 2) && rd) m_dlo = eng_rdata[7:0];
                    if ((m_pr == 3 && rd) || m_pr == 4) begin
                        m_dlo = eng_rdata[7:0]; m_dhi = eng_rdata[15:8];
                    end
                    if ((m_pr == 5 && rd) || m_pr == 6) begin
                        m_dlo = eng_rdata[7:0]; m_blk = eng_rdata[15:8]; m_st[7] = 1;
                    end
                end
                if (eng_bus_err) m_st[3] = 1;
            end
            if (eng_alert) m_st[5] = 1;
            if (reg_wr) begin
                case (reg_addr)
                    4'h2: begin
                        m_ctl = reg_wdata & 8'hBF;
                        if (reg_wdata[1]) begin
                            m_st[4] = 1; m_st[0] = 0; m_abt = 1;
                        end else if (reg_wdata[6] && !ob && !od) begin
                            if (reg_wdata[4:2] == 3'd7) m_st[2] = 1;
                            else begin m_st[0] = 1; m_req = 1; m_pr = reg_wdata[4:2]; end
                        end
                    end
                    4'h3: if (!ob) m_cmd = reg_wdata;
                    4'h4: if (!ob) m_adr = reg_wdata;
                    4'h5: if (!ob) m_dlo = reg_wdata;
                    4'h6: if (!ob) m_dhi = reg_wdata;
                    4'h7: if (!ob) m_blk = reg_wdata;
                    4'hD: m_aux = reg_wdata[1:0];
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the reference
    always @(negedge clk) begin
        #1;
        if (!rst && !finished) begin
            chk("R1 rdata", {8'h0, reg_rdata}, {8'h0, m_read(reg_addr)});
            chk("R10 irq", {15'h0, irq}, {15'h0, m_ctl[0] && (m_st[7:1] != 0)});
            chk("R5 req", {15'h0, eng_req}, {15'h0, m_req});
            chk("R7 abort", {15'h0, eng_abort}, {15'h0, m_abt});
            if (m_req) begin
                chk("R5 proto", {13'h0, eng_proto}, {13'h0, m_pr});
                chk("R5 slave", {8'h0, eng_rnw, eng_slave}, {8'h0, m_adr[0], m_adr[7:1]});
                chk("R9 wdata", eng_wdata, {m_dhi, m_dlo});
            end
        end
    end

    task automatic wr(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rdx(logic [3:0] a, logic [7:0] exp, string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(tag, {8'h0, reg_rdata}, {8'h0, exp});
    endtask

    task automatic edone(logic nak, logic berr, logic [15:0] d);
        @(negedge clk);
        eng_done = 1; eng_nak = nak; eng_bus_err = berr; eng_rdata = d;
        @(negedge clk);
        eng_done = 0; eng_nak = 0; eng_bus_err = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        rdx(4'h0, 8'h00, "R2 status");
        rdx(4'h2, 8'h00, "R2 control");
        rdx(4'h5, 8'h00, "R2 data-low");
        chk("R2 irq/req", {14'h0, irq, eng_req}, 16'h0);

        wr(4'h3, 8'h5A); wr(4'h4, 8'hA0); wr(4'h5, 8'h34); wr(4'h6, 8'h12);
        wr(4'h7, 8'h77); wr(4'hD, 8'hFF);
        rdx(4'hD, 8'h03, "R1 aux");
        rdx(4'h1, 8'h00, "R1 unmapped");
        rdx(4'h4, 8'hA0, "R1 address");
        rdx(4'h7, 8'h77, "R1 block");

        // word write
        wr(4'h2, 8'h4C);
        chk("R5 req", {15'h0, eng_req}, 16'h1);
        chk("R5 proto", {13'h0, eng_proto}, 16'h3);
        chk("R5 slave", {9'h0, eng_slave}, 16'h50);
        chk("R5 rnw", {15'h0, eng_rnw}, 16'h0);
        chk("R5 cmd", {8'h0, eng_cmd}, 16'h5A);
        chk("R9 packing", eng_wdata, 16'h1234);
        rdx(4'h2, 8'h0C, "R4 control read");
        rdx(4'h0, 8'h01, "R5 busy");
        wr(4'h3, 8'h00);
        rdx(4'h3, 8'h5A, "R11 cmd locked");
        wr(4'h0, 8'hFF);
        rdx(4'h0, 8'h01, "R3 busy kept");
        edone(0, 0, 16'h0);
        rdx(4'h0, 8'h02, "R8 done");
        chk("R10 irq off", {15'h0, irq}, 16'h0);
        wr(4'h2, 8'h01);
        chk("R10 irq on", {15'h0, irq}, 16'h1);
        wr(4'h0, 8'h02);
        rdx(4'h0, 8'h00, "R3 w1c");
        chk("R10 irq cleared", {15'h0, irq}, 16'h0);

        // word read
        wr(4'h4, 8'hA1); wr(4'h2, 8'h4D);
        edone(0, 0, 16'hBEEF);
        rdx(4'h5, 8'hEF, "R9 word low");
        rdx(4'h6, 8'hBE, "R9 word high");
        wr(4'h0, 8'h02);

        // byte-data read
        wr(4'h2, 8'h49);
        edone(0, 0, 16'h1155);
        rdx(4'h5, 8'h55, "R9 byte low");
        rdx(4'h6, 8'hBE, "R9 byte high untouched");
        wr(4'h0, 8'h02);

        // block read
        wr(4'h2, 8'h55);
        edone(0, 0, 16'hC903);
        rdx(4'h5, 8'h03, "R9 block count");
        rdx(4'h7, 8'hC9, "R9 block byte");
        rdx(4'h0, 8'h82, "R9 byte done");
        wr(4'h0, 8'h82);

        // NAK and lockout
        wr(4'h4, 8'hA0); wr(4'h2, 8'h45);
        edone(1, 0, 16'h0);
        rdx(4'h0, 8'h04, "R8 nak");
        wr(4'h2, 8'h45);
        chk("R6 no req", {15'h0, eng_req}, 16'h0);
        rdx(4'h0, 8'h04, "R6 still idle");
        wr(4'h0, 8'h04);

        // reserved protocol
        wr(4'h2, 8'h5D);
        chk("R6 reserved no req", {15'h0, eng_req}, 16'h0);
        rdx(4'h0, 8'h04, "R6 reserved dev err");
        wr(4'h0, 8'h04);

        // kill
        wr(4'h2, 8'h4D);
        wr(4'h2, 8'h03);
        chk("R7 abort", {15'h0, eng_abort}, 16'h1);
        rdx(4'h0, 8'h10, "R7 failed");
        edone(0, 0, 16'hFFFF);
        rdx(4'h0, 8'h10, "R7 late done ignored");
        wr(4'h0, 8'h10);
        wr(4'h2, 8'h43);
        chk("R7 kill beats start", {15'h0, eng_req}, 16'h0);
        wr(4'h0, 8'h10);

        // alert
        @(negedge clk); eng_alert = 1;
        @(negedge clk); eng_alert = 0;
        rdx(4'h0, 8'h20, "R12 alert");
        wr(4'h0, 8'h20);

        // quick command with bus error
        wr(4'h2, 8'h41);
        edone(0, 1, 16'hAAAA);
        rdx(4'h0, 8'h0A, "R8 bus error");
        rdx(4'h5, 8'h03, "R9 quick no capture");

        repeat (4) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule